// File: doc/BRIEF.md
# Dual-Channel Disk Interrupt Combiner

This block merges the level interrupt requests of two disk channels into one active-high interrupt line for a host bus. It holds a mode byte in which each channel owns a pending flag and a block flag. A pending flag tracks its channel's request level on every clock. The shared line is raised whenever some channel has its pending flag set and its block flag clear.

The pending flags are also copied into two legacy status bytes, one per channel, for older software that polls those locations. The host can write the mode byte, but a write changes only the block flags. The mode byte and both legacy bytes can be read at all times.

All state sits in registers. A change on a request input or a host write shows on every output one clock edge later.

Top module: `ide_irq_combiner`

## Requirements
- R1: While `rst_ni` is low, and after it is released until the first input change, `mode_o`, `legacy0_o` and `legacy1_o` read 0x00 and `irq_o` is low.
- R2: A high level on `chan_irq_i[0]` sets bit 2 of `mode_o`, and a high level on `chan_irq_i[1]` sets bit 3. Each bit shows the input as it was sampled at the previous rising clock edge.
- R3: A low level on a channel input clears that channel's pending bit, which is bit 2 or bit 3 of `mode_o`, at the next rising edge. A pending bit never stays set once its input is low.
- R4: A write (`mode_we_i` high at a rising edge) loads `mode_wdata_i[4]` into the channel 0 block bit (`mode_o[4]`) and `mode_wdata_i[5]` into the channel 1 block bit (`mode_o[5]`). The written values of bits 0-3, 6 and 7 have no effect. The block bits hold their value while no write is made.
- R5: `irq_o` equals (`mode_o[2]` AND NOT `mode_o[4]`) OR (`mode_o[3]` AND NOT `mode_o[5]`) in every cycle. It therefore changes in the same cycle as the mode byte it depends on.
- R6: `legacy0_o` carries the channel 0 pending bit at bit 2 and `legacy1_o` carries the channel 1 pending bit at bit 4. All other bits of both bytes read 0.
- R7: A channel input change and a host write in the same cycle both take effect at the same next edge.
- R8: Bits 0, 1, 6 and 7 of `mode_o` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_irq_i | input | 2 | Level interrupt request, one bit per channel |
| mode_we_i | input | 1 | Host write strobe for the mode byte |
| mode_wdata_i | input | 8 | Host write data for the mode byte |
| mode_o | output | 8 | Mode byte: pending flags at bits 3:2, block flags at bits 5:4 |
| legacy0_o | output | 8 | Legacy status byte for channel 0 (pending at bit 2) |
| legacy1_o | output | 8 | Legacy status byte for channel 1 (pending at bit 4) |
| irq_o | output | 1 | Combined active-high interrupt line |

## Verification
The bench writes all ones to the non-block bits of the mode byte while both channels are pending. A design that let the write reach the pending flags, or that stored the reserved bits, would show a changed mode byte.

The bench also falls a channel input in the same cycle as a block write. A design that gave either path priority would lose the clear or the mask. Masking one channel while the other stays active checks that the line is the OR of the unmasked channels rather than a plain OR of the pending flags.

Two more cases target the legacy bytes and the clearing of pending flags. Swapped mirror positions would misplace the legacy bits. A pending flag latched as sticky would keep the line up after the request drops.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;
  localparam int NUM_CH   = 2;
  localparam int REG_W    = 8;
  localparam int PEND_LSB = 2;
  localparam int BLK_LSB  = 4;

  // bit position of each channel's pending copy in its legacy byte
  function automatic int mirror_bit(input int ch);
    return (ch == 0) ? 2 : 4;
  endfunction
endpackage

// File: rtl/ide_irq_pend.sv
module ide_irq_pend #(
  parameter int NumCh = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NumCh-1:0] req_i,
  output logic [NumCh-1:0] pend_o
);
  for (genvar c = 0; c < NumCh; c++) begin : g_ch
    logic pend_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q <= 1'b0;
      else         pend_q <= req_i[c];
    end
    assign pend_o[c] = pend_q;
  end
endmodule

// File: rtl/ide_irq_mask.sv
module ide_irq_mask #(
  parameter int NumCh  = 2,
  parameter int RegW   = 8,
  parameter int BlkLsb = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [RegW-1:0]  wdata_i,
  output logic [NumCh-1:0] blk_o
);
  logic [NumCh-1:0] blk_q;
  logic             unused_wdata;

  // only the block field is writable; other bits are dropped
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   blk_q <= '0;
    else if (we_i) blk_q <= wdata_i[BlkLsb +: NumCh];
  end

  assign blk_o = blk_q;
endmodule

// File: rtl/ide_irq_merge.sv
module ide_irq_merge #(
  parameter int NumCh = 2
) (
  input  logic [NumCh-1:0] pend_i,
  input  logic [NumCh-1:0] blk_i,
  output logic             irq_o
);
  logic [NumCh-1:0] live;
  assign live  = pend_i & ~blk_i;
  assign irq_o = |live;
endmodule

// File: rtl/ide_irq_mirror.sv
module ide_irq_mirror
  import ide_irq_pkg::*;
#(
  parameter int NumCh = 2,
  parameter int RegW  = 8
) (
  input  logic [NumCh-1:0]           pend_i,
  output logic [NumCh-1:0][RegW-1:0] leg_o
);
  for (genvar c = 0; c < NumCh; c++) begin : g_leg
    localparam int Pos = mirror_bit(c);
    always_comb begin
      leg_o[c]      = '0;
      leg_o[c][Pos] = pend_i[c];
    end
  end
endmodule

// File: rtl/ide_irq_combiner.sv
module ide_irq_combiner
  import ide_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] chan_irq_i,
  input  logic              mode_we_i,
  input  logic [REG_W-1:0]  mode_wdata_i,
  output logic [REG_W-1:0]  mode_o,
  output logic [REG_W-1:0]  legacy0_o,
  output logic [REG_W-1:0]  legacy1_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0]            pend;
  logic [NUM_CH-1:0]            blk;
  logic [NUM_CH-1:0][REG_W-1:0] leg;

  ide_irq_pend #(.NumCh(NUM_CH)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (chan_irq_i),
    .pend_o (pend)
  );

  ide_irq_mask #(.NumCh(NUM_CH), .RegW(REG_W), .BlkLsb(BLK_LSB)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mode_we_i),
    .wdata_i (mode_wdata_i),
    .blk_o   (blk)
  );

  ide_irq_merge #(.NumCh(NUM_CH)) u_merge (
    .pend_i (pend),
    .blk_i  (blk),
    .irq_o  (irq_o)
  );

  ide_irq_mirror #(.NumCh(NUM_CH), .RegW(REG_W)) u_mirror (
    .pend_i (pend),
    .leg_o  (leg)
  );

  always_comb begin
    mode_o                       = '0;
    mode_o[PEND_LSB +: NUM_CH]   = pend;
    mode_o[BLK_LSB +: NUM_CH]    = blk;
  end

  assign legacy0_o = leg[0];
  assign legacy1_o = leg[1];
endmodule

// File: rtl/ide_irq_combiner_chk.sv
module ide_irq_combiner_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] chan_irq_i,
  input logic       mode_we_i,
  input logic [7:0] mode_wdata_i,
  input logic [7:0] mode_o,
  input logic [7:0] legacy0_o,
  input logic [7:0] legacy1_o,
  input logic       irq_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R2
  pend0_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> mode_o[2] == $past(chan_irq_i[0]));
  // R3
  pend1_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> mode_o[3] == $past(chan_irq_i[1]));
  // R4
  blk_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_i |=> mode_o[5:4] == $past(mode_wdata_i[5:4]));
  // R4
  blk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !mode_we_i) |=> $stable(mode_o[5:4]));
  // R5
  irq_merge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == ((mode_o[2] && !mode_o[4]) || (mode_o[3] && !mode_o[5])));
  // R6
  mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legacy0_o == {5'b0, mode_o[2], 2'b0} && legacy1_o == {3'b0, mode_o[3], 4'b0});
  // R8
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o[1:0] == 2'b00 && mode_o[7:6] == 2'b00);
endmodule

bind ide_irq_combiner ide_irq_combiner_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .chan_irq_i   (chan_irq_i),
  .mode_we_i    (mode_we_i),
  .mode_wdata_i (mode_wdata_i),
  .mode_o       (mode_o),
  .legacy0_o    (legacy0_o),
  .legacy1_o    (legacy1_o),
  .irq_o        (irq_o)
);

// File: tb/ide_irq_combiner_tb.sv
module ide_irq_combiner_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] chan_irq = 2'b00;
  logic       we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] mode, leg0, leg1;
  logic       irq;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int         due;
    logic [7:0] mode;
    logic [7:0] leg0;
    logic [7:0] leg1;
    logic       irq;
    string      tag;
  } exp_t;
  exp_t q[$];

  logic [1:0] m_pend = 2'b00;
  logic [1:0] m_blk = 2'b00;

  always #10 clk = ~clk;

  ide_irq_combiner u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .chan_irq_i   (chan_irq),
    .mode_we_i    (we),
    .mode_wdata_i (wdata),
    .mode_o       (mode),
    .legacy0_o    (leg0),
    .legacy1_o    (leg1),
    .irq_o        (irq)
  );

  task automatic chk8(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and queue the expected result
  task automatic step(input logic [1:0] req, input logic w, input logic [7:0] d, input string tag);
    exp_t e;
    @(posedge clk);
    #2;
    chan_irq = req;
    we = w;
    wdata = d;
    m_pend = req;
    if (w) m_blk = d[5:4];
    e.due  = cyc + 1;
    e.mode = {2'b00, m_blk, m_pend, 2'b00};
    e.leg0 = {5'b0, m_pend[0], 2'b0};
    e.leg1 = {3'b0, m_pend[1], 4'b0};
    e.irq  = (m_pend[0] & ~m_blk[0]) | (m_pend[1] & ~m_blk[1]);
    e.tag  = tag;
    q.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #5;
      while (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        chk8(e.tag, "mode", mode, e.mode);
        chk8(e.tag, "legacy0", leg0, e.leg0);
        chk8(e.tag, "legacy1", leg1, e.leg1);
        chk8(e.tag, "irq", {7'b0, irq}, {7'b0, e.irq});
      end
    end
  end

  initial begin
    logic [7:0] lfsr = 8'hA5;
    #25;
    // R1 during reset
    chk8("R1", "mode", mode, 8'h00);
    chk8("R1", "legacy0", leg0, 8'h00);
    chk8("R1", "legacy1", leg1, 8'h00);
    chk8("R1", "irq", {7'b0, irq}, 8'h00);
    #10 rst_n = 1'b1;
    step(2'b00, 1'b0, 8'h00, "R1");
    step(2'b01, 1'b0, 8'h00, "R2");
    step(2'b11, 1'b0, 8'h00, "R2");
    step(2'b10, 1'b0, 8'h00, "R3");
    step(2'b00, 1'b0, 8'h00, "R3");
    step(2'b01, 1'b1, 8'h10, "R7");
    step(2'b11, 1'b0, 8'h00, "R5");
    step(2'b11, 1'b1, 8'h30, "R5");
    step(2'b11, 1'b1, 8'hCF, "R4");
    step(2'b11, 1'b0, 8'hFF, "R8");
    step(2'b10, 1'b1, 8'h20, "R7");
    step(2'b00, 1'b0, 8'h00, "R6");
    step(2'b01, 1'b0, 8'h00, "R6");
    step(2'b10, 1'b0, 8'h00, "R6");
    step(2'b10, 1'b1, 8'h10, "R4");
    for (int i = 0; i < 48; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[1:0], lfsr[6], {lfsr[3:0], lfsr[7:4]}, "R5");
    end
    step(2'b00, 1'b0, 8'h00, "R3");
    repeat (3) @(posedge clk);
    #6;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R5 pending items actual=%0d expected=0", q.size());
    end
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule